// File: doc/BRIEF.md
# Accumulator and Flag Unit with Selectable Flag Model

This block holds an 8-bit accumulator and its flag byte. On each clock it can apply one arithmetic, logic, rotate or complement operation to the accumulator and an operand. It can also load the accumulator/flag pair from a 16-bit word, which is the path a stack pop uses. The 16-bit pair is always visible on an output for a stack push. Flags that an operation does not affect keep their old values.

A static mode input picks the flag model. In the full model the flag byte has eight bits, including the two bits that copy result bits 5 and 3. In the reduced model only four flags exist, in the upper nibble. The lower nibble is forced to zero on every write path, including the word load, so a later push never carries stale bits.

Top module: `flagalu_top`

## Requirements
- R1: While rst_n is low, and at the first sample after reset, a_out and f_out are both 0x00.
- R2: The opcode encoding is 0 ADD, 1 SUB, 2 AND, 3 XOR, 4 OR, 5 INC, 6 DEC, 7 CPL, 8 RRA. In the full model (lite_mode=0) the flag byte is S,Z,Y,H,X,P,N,C from bit 7 down to bit 0. ADD and SUB write every flag: S is result bit 7, Z means a zero result, H is the carry out of bit 3 (for SUB, the borrow from bit 4), P is signed overflow, N is 0 for ADD and 1 for SUB, and C is the carry or borrow out of bit 7.
- R3: AND sets H. OR and XOR clear H. All three clear N and C, set P on even parity of the result, and set S and Z from the result. XOR A followed by AND A gives F=0x54 in the full model.
- R4: INC and DEC never change C. H reports a carry into bit 4 (for DEC, a borrow from bit 4). P is set when INC starts from 0x7F or DEC starts from 0x80. N is 0 for INC and 1 for DEC. After XOR A, DEC A gives A=0xFF and F=0xBA.
- R5: In the full model, Y and X take result bits 5 and 3 for every operation.
- R6: CPL inverts A and sets H and N. S, Z, P and C keep their values, so after XOR A the flag byte goes from 0x44 to 0x7E.
- R7: RRA shifts A right. The old C enters bit 7 and the old bit 0 becomes C. H and N are cleared, and S, Z and P keep their values. SUB A followed by RRA leaves F=0x40.
- R8: In the reduced model (lite_mode=1) the flag byte holds Z,N,H,C in bits 7 to 4, and f_out bits 3 to 0 are always zero. The flag rules are the same as in the full model. XOR A then INC A gives af_out=0x0100.
- R9: When pop_en is high, A takes pop_word[15:8] and F takes pop_word[7:0] masked by the mode (low nibble cleared in the reduced model). af_out always equals {a_out, f_out}.
- R10: With neither op_valid nor pop_en high, A and F hold their values.
- R11: If pop_en and op_valid are high in the same cycle, the pop wins and the operation is dropped.
- R12: Opcodes 9 to 15 with op_valid high leave A and F unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lite_mode | input | 1 | 1 selects the reduced four-flag model |
| op_valid | input | 1 | Apply op_code this cycle |
| op_code | input | 4 | Operation select (see R2) |
| operand | input | 8 | Second operand for ADD, SUB, AND, XOR, OR |
| pop_en | input | 1 | Load A and F from pop_word |
| pop_word | input | 16 | Word to load: A in the high byte, F in the low byte |
| a_out | output | 8 | Accumulator |
| f_out | output | 8 | Flag byte |
| af_out | output | 16 | Accumulator/flag pair for a push |

## Verification
The checker assumes that lite_mode changes only while rst_n is low. Under that assumption the zero low nibble in the reduced model holds from reset onward, and the carry position seen by the checks is fixed. The bench resets the block before each mode change and holds lite_mode steady for the whole run of that mode. The checks on operation effects assume that pop_en is low in the same cycle, and the bench only drives the two together in the dedicated priority test.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;

    localparam int unsigned ACC_W = 8;
    localparam int unsigned NIB_W = ACC_W / 2;
    localparam int unsigned PAIR_W = 2 * ACC_W;
    localparam logic [ACC_W-1:0] LITE_KEEP = {{NIB_W{1'b1}}, {NIB_W{1'b0}}};

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_XOR = 4'd3,
        OP_OR  = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_CPL = 4'd7,
        OP_RRA = 4'd8
    } alu_op_e;

    // bit order matches the full-model flag byte, MSB first
    typedef struct packed {
        logic s;
        logic z;
        logic y;
        logic h;
        logic x;
        logic p;
        logic n;
        logic c;
    } flag_set_t;

    typedef struct packed {
        logic [ACC_W-1:0] res;
        flag_set_t        val;
        flag_set_t        wen;
        logic             known;
    } alu_res_t;

    typedef struct packed {
        logic [ACC_W-1:0] a;
        logic [ACC_W-1:0] f;
    } acc_state_t;

    function automatic logic [ACC_W-1:0] flag_mask(input logic lite,
                                                   input logic [ACC_W-1:0] raw);
        return lite ? (raw & LITE_KEEP) : raw;
    endfunction

endpackage

// File: rtl/flagalu_arith.sv
module flagalu_arith
    import flagalu_pkg::*;
(
    input  logic [3:0]       op,
    input  logic [ACC_W-1:0] a,
    input  logic [ACC_W-1:0] b,
    input  logic             cin,
    output alu_res_t         o
);

    logic [ACC_W:0]   sum_w;
    logic [ACC_W:0]   dif_w;
    logic [NIB_W:0]   hsum_w;
    logic [NIB_W:0]   hdif_w;

    always_comb begin
        sum_w  = {1'b0, a} + {1'b0, b};
        dif_w  = {1'b0, a} - {1'b0, b};
        hsum_w = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]};
        hdif_w = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]};

        o       = '0;
        o.known = 1'b1;
        o.wen   = flag_set_t'(8'hFF);

        unique case (op)
            OP_ADD: begin
                o.res   = sum_w[ACC_W-1:0];
                o.val.c = sum_w[ACC_W];
                o.val.h = hsum_w[NIB_W];
                o.val.p = (a[ACC_W-1] == b[ACC_W-1]) && (o.res[ACC_W-1] != a[ACC_W-1]);
                o.val.n = 1'b0;
            end
            OP_SUB: begin
                o.res   = dif_w[ACC_W-1:0];
                o.val.c = dif_w[ACC_W];
                o.val.h = hdif_w[NIB_W];
                o.val.p = (a[ACC_W-1] != b[ACC_W-1]) && (o.res[ACC_W-1] != a[ACC_W-1]);
                o.val.n = 1'b1;
            end
            OP_AND, OP_XOR, OP_OR: begin
                if (op == OP_AND)      o.res = a & b;
                else if (op == OP_XOR) o.res = a ^ b;
                else                   o.res = a | b;
                o.val.h = (op == OP_AND);
                o.val.p = ~^o.res;
                o.val.n = 1'b0;
                o.val.c = 1'b0;
            end
            OP_INC: begin
                o.res   = a + 1'b1;
                o.val.h = &a[NIB_W-1:0];
                o.val.p = (a == {1'b0, {(ACC_W-1){1'b1}}});
                o.val.n = 1'b0;
                o.wen.c = 1'b0;
            end
            OP_DEC: begin
                o.res   = a - 1'b1;
                o.val.h = ~|a[NIB_W-1:0];
                o.val.p = (a == {1'b1, {(ACC_W-1){1'b0}}});
                o.val.n = 1'b1;
                o.wen.c = 1'b0;
            end
            OP_CPL: begin
                o.res   = ~a;
                o.val.h = 1'b1;
                o.val.n = 1'b1;
                o.wen   = flag_set_t'(8'h3A);
            end
            OP_RRA: begin
                o.res   = {cin, a[ACC_W-1:1]};
                o.val.c = a[0];
                o.val.h = 1'b0;
                o.val.n = 1'b0;
                o.wen   = flag_set_t'(8'h3B);
            end
            default: begin
                o.known = 1'b0;
                o.wen   = '0;
                o.res   = a;
            end
        endcase

        // result-derived flags; wen decides whether they land
        o.val.s = o.res[ACC_W-1];
        o.val.z = ~|o.res;
        o.val.y = o.res[5];
        o.val.x = o.res[3];
    end

endmodule

// File: rtl/flagalu_pack.sv
module flagalu_pack
    import flagalu_pkg::*;
(
    input  logic             lite,
    input  logic [ACC_W-1:0] f_old,
    input  alu_res_t         alu,
    output logic             c_old,
    output logic [ACC_W-1:0] f_new
);

    flag_set_t old_fs;
    flag_set_t mrg_fs;

    always_comb begin
        old_fs = '0;
        if (lite) begin
            old_fs.z = f_old[7];
            old_fs.n = f_old[6];
            old_fs.h = f_old[5];
            old_fs.c = f_old[4];
        end else begin
            old_fs = flag_set_t'(f_old);
        end
        c_old = old_fs.c;

        mrg_fs = (alu.val & alu.wen) | (old_fs & ~alu.wen);

        if (lite) f_new = {mrg_fs.z, mrg_fs.n, mrg_fs.h, mrg_fs.c, {NIB_W{1'b0}}};
        else      f_new = mrg_fs;
    end

endmodule

// File: rtl/flagalu_top.sv
module flagalu_top
    import flagalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lite_mode,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [ACC_W-1:0]  operand,
    input  logic              pop_en,
    input  logic [PAIR_W-1:0] pop_word,
    output logic [ACC_W-1:0]  a_out,
    output logic [ACC_W-1:0]  f_out,
    output logic [PAIR_W-1:0] af_out
);

    acc_state_t       st_q;
    acc_state_t       st_d;
    alu_res_t         alu_w;
    logic             cin_w;
    logic [ACC_W-1:0] f_alu_w;

    flagalu_pack u_pack (
        .lite  (lite_mode),
        .f_old (st_q.f),
        .alu   (alu_w),
        .c_old (cin_w),
        .f_new (f_alu_w)
    );

    flagalu_arith u_arith (
        .op  (op_code),
        .a   (st_q.a),
        .b   (operand),
        .cin (cin_w),
        .o   (alu_w)
    );

    always_comb begin
        st_d = st_q;
        if (pop_en) begin
            st_d.a = pop_word[PAIR_W-1:ACC_W];
            st_d.f = flag_mask(lite_mode, pop_word[ACC_W-1:0]);
        end else if (op_valid && alu_w.known) begin
            st_d.a = alu_w.res;
            st_d.f = flag_mask(lite_mode, f_alu_w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_out  = st_q.a;
    assign f_out  = st_q.f;
    assign af_out = st_q;

endmodule

// File: rtl/flagalu_chk.sv
module flagalu_chk
    import flagalu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lite_mode,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic              pop_en,
    input logic [PAIR_W-1:0] pop_word,
    input logic [ACC_W-1:0]  a_out,
    input logic [ACC_W-1:0]  f_out
);

    logic is_op;
    logic c_now;
    logic h_now;
    assign is_op = op_valid && !pop_en;
    assign c_now = lite_mode ? f_out[4] : f_out[0];
    assign h_now = lite_mode ? f_out[5] : f_out[4];

    assert_pop_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |=> a_out == $past(pop_word[PAIR_W-1:ACC_W]));

    assert_lite_nibble_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lite_mode |-> f_out[NIB_W-1:0] == '0);

    assert_incdec_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_op && (op_code == OP_INC || op_code == OP_DEC)) |=> c_now == $past(c_now));

    assert_and_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_op && op_code == OP_AND) |=> h_now);

    assert_cpl_invert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_op && op_code == OP_CPL) |=> a_out == ~$past(a_out));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !pop_en) |=> ($stable(a_out) && $stable(f_out)));

    assert_bad_op_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (is_op && op_code > 4'd8) |=> ($stable(a_out) && $stable(f_out)));

endmodule

bind flagalu_top flagalu_chk u_chk (.*);

// File: tb/tb_flagalu_top.sv
module tb_flagalu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lite_mode = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [7:0]  operand = '0;
    logic        pop_en = 1'b0;
    logic [15:0] pop_word = '0;
    logic [7:0]  a_out;
    logic [7:0]  f_out;
    logic [15:0] af_out;

    int n_run = 0;
    int n_bad = 0;
    int ma = 0;
    int mf = 0;

    always #2.5 clk = ~clk;

    flagalu_top dut (.*);

    task automatic check(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic int par_even(input int v);
        int cnt = 0;
        for (int i = 0; i < 8; i++) cnt += (v >> i) & 1;
        return (cnt % 2 == 0) ? 1 : 0;
    endfunction

    // behavioural reference: returns {A,F}
    function automatic int ref_next(input int lite, input int a, input int f,
                                    input int op, input int b);
        int s, z, y, h, x, p, n, c, r, rf;
        if (lite != 0) begin
            z = (f >> 7) & 1; n = (f >> 6) & 1; h = (f >> 5) & 1; c = (f >> 4) & 1;
            s = 0; y = 0; x = 0; p = 0;
        end else begin
            s = (f >> 7) & 1; z = (f >> 6) & 1; y = (f >> 5) & 1; h = (f >> 4) & 1;
            x = (f >> 3) & 1; p = (f >> 2) & 1; n = (f >> 1) & 1; c = f & 1;
        end
        case (op)
            0: begin r = a + b; c = (r > 255); h = ((a & 15) + (b & 15)) > 15; r &= 255;
                     p = (((a ^ r) & (b ^ r) & 128) != 0); n = 0; end
            1: begin c = (a < b); h = ((a & 15) < (b & 15)); r = (a - b) & 255;
                     p = (((a ^ b) & (a ^ r) & 128) != 0); n = 1; end
            2, 3, 4: begin
                     r = (op == 2) ? (a & b) : (op == 3) ? (a ^ b) : (a | b);
                     h = (op == 2); n = 0; c = 0; p = par_even(r); end
            5: begin r = (a + 1) & 255; h = ((a & 15) == 15); p = (a == 127); n = 0; end
            6: begin r = (a + 255) & 255; h = ((a & 15) == 0); p = (a == 128); n = 1; end
            7: begin r = (~a) & 255; h = 1; n = 1; end
            8: begin r = (a >> 1) | (c << 7); c = a & 1; h = 0; n = 0; end
            default: return (a << 8) | f;
        endcase
        if (op <= 6) begin s = (r >> 7) & 1; z = (r == 0); end
        y = (r >> 5) & 1; x = (r >> 3) & 1;
        if (lite != 0) rf = (z << 7) | (n << 6) | (h << 5) | (c << 4);
        else rf = (s << 7) | (z << 6) | (y << 5) | (h << 4) | (x << 3) | (p << 2) | (n << 1) | c;
        return (r << 8) | rf;
    endfunction

    function automatic string op_tag(input int op);
        case (op)
            0, 1: return "R2 add/sub";
            2, 3, 4: return "R3 logic";
            5, 6: return "R4 inc/dec";
            7: return "R6 cpl";
            8: return "R7 rra";
            default: return "R12 bad opcode";
        endcase
    endfunction

    task automatic do_reset(input logic lite);
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0; pop_en = 1'b0;
        lite_mode = lite;
        @(negedge clk);
        check("R1 reset a", a_out, 0);
        check("R1 reset f", f_out, 0);
        rst_n = 1'b1;
        ma = 0; mf = 0;
        @(posedge clk); #1;
        check("R1 after reset", af_out, 0);
    endtask

    // one cycle: drive at negedge, compare just after the next rising edge
    task automatic step(input logic v, input int op, input int b,
                        input logic pe, input int pw, input string tag);
        int nx;
        @(negedge clk);
        op_valid = v; op_code = op[3:0]; operand = b[7:0];
        pop_en = pe; pop_word = pw[15:0];
        @(posedge clk); #1;
        if (pe) begin
            ma = (pw >> 8) & 255;
            mf = pw & (lite_mode ? 8'hF0 : 8'hFF);
        end else if (v) begin
            nx = ref_next(lite_mode, ma, mf, op, b);
            ma = (nx >> 8) & 255; mf = nx & 255;
        end
        check(tag, af_out, (ma << 8) | mf);
        check("R9 af pair", af_out, {a_out, f_out});
        if (lite_mode) check("R8 low nibble", f_out & 15, 0);
    endtask

    task automatic random_run(input int count);
        int op, kind;
        for (int i = 0; i < count; i++) begin
            kind = $urandom_range(0, 9);
            op = $urandom_range(0, 8);
            if (kind == 0) step(1'b0, op, 0, 1'b1, $urandom_range(0, 65535), "R9 pop");
            else if (kind == 1) step(1'b0, op, 0, 1'b0, 0, "R10 idle");
            else if (kind == 2) step(1'b1, $urandom_range(9, 15), $urandom_range(0, 255),
                                     1'b0, 0, "R12 bad opcode");
            else step(1'b1, op, $urandom_range(0, 255), 1'b0, 0, op_tag(op));
        end
    endtask

    initial begin
        #(200000 * 5);
        n_run++; n_bad++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        // ---- full flag model ----
        do_reset(1'b0);
        step(1'b1, 3, 0, 1'b0, 0, "R3 xor a");
        check("R3 xor a flags", f_out, 8'h44);
        step(1'b1, 2, 0, 1'b0, 0, "R3 and a");
        check("R3 and a flags", f_out, 8'h54);
        step(1'b1, 3, 0, 1'b0, 0, "R3 xor a");
        step(1'b1, 6, 0, 1'b0, 0, "R4 dec");
        check("R4 dec 00 result", af_out, 16'hFFBA);
        step(1'b1, 3, 8'hFF, 1'b0, 0, "R3 xor to zero");
        step(1'b1, 7, 0, 1'b0, 0, "R6 cpl");
        check("R6 cpl flags", af_out, 16'hFF7E);
        check("R5 y/x copied", f_out & 8'h28, 8'h28);
        step(1'b1, 1, 8'hFF, 1'b0, 0, "R2 sub a");
        check("R2 sub a", af_out, 16'h0042);
        step(1'b1, 8, 0, 1'b0, 0, "R7 rra");
        check("R7 rra flags", f_out, 8'h40);
        step(1'b0, 0, 0, 1'b1, 16'h7F01, "R9 pop full");
        check("R9 pop full keeps low bits", af_out, 16'h7F01);
        step(1'b1, 5, 0, 1'b0, 0, "R4 inc 7f");
        check("R4 inc overflow keeps carry", f_out & 8'h05, 8'h05);
        step(1'b1, 0, 8'h01, 1'b1, 16'h1234, "R11 pop wins");
        check("R11 pop wins", af_out, 16'h1234);
        step(1'b1, 0, 8'h70, 1'b0, 0, "R2 add overflow");
        step(1'b1, 12, 8'h55, 1'b0, 0, "R12 bad opcode");
        step(1'b0, 0, 0, 1'b0, 0, "R10 idle");
        random_run(3000);

        // ---- reduced flag model ----
        do_reset(1'b1);
        step(1'b1, 3, 0, 1'b0, 0, "R8 xor a");
        step(1'b1, 5, 0, 1'b0, 0, "R8 inc a");
        check("R8 push word", af_out, 16'h0100);
        step(1'b0, 0, 0, 1'b1, 16'hA5FF, "R9 pop masked");
        check("R9 pop masked", af_out, 16'hA5F0);
        step(1'b1, 2, 8'h0F, 1'b0, 0, "R3 and reduced");
        check("R3 and sets h reduced", f_out, 8'h20);
        step(1'b1, 6, 0, 1'b0, 0, "R4 dec reduced");
        step(1'b1, 7, 0, 1'b0, 0, "R6 cpl reduced");
        step(1'b1, 8, 0, 1'b0, 0, "R7 rra reduced");
        random_run(3000);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule